// File: doc/BRIEF.md
# Segmented Paged Address Translator

This block turns a virtual address into a physical address in two steps. The top bits of the address pick one of a small set of segment descriptors held inside the block. Each descriptor has a loaded flag, access rights, a byte limit and the base address of that segment's page table. The descriptor is checked against the request. If the checks pass, the block fetches one page-table entry through a single-beat memory read port. The frame number from that entry is then joined with the page offset to form the physical address.

A request is accepted with a valid/ready handshake, and only one translation is in flight at a time. Every request produces one result with one status code: success, segment not loaded, access type not permitted, reference past the segment's end, or page not present. When a check on the descriptor fails, the block answers without touching memory. The descriptors are loaded through a write port that is separate from the request path.

Top module: `seg_page_xlate`

## Requirements
- R1: The 16-bit virtual address is split as segment = bits [15:13], page = bits [12:8], offset = bits [7:0]. The page-table entry is read at address (descriptor table base + page), 16 bits wide, with wrap-around.
- R2: A request to a segment whose loaded flag is 0 returns status 1 (segment fault) and issues no memory read.
- R3: Access code 0 = read, 1 = write, 2 = execute. Each is allowed only when rights bit 0, 1 or 2 respectively is set. Code 3 is never allowed. A disallowed access returns status 2 (protection error) and issues no memory read.
- R4: The limit is a 14-bit byte count. A request whose combined {page, offset} is greater than or equal to the limit returns status 3 (limit error) and issues no memory read. This means a segment's last page may be only partly usable, and a limit of 8192 covers the whole segment.
- R5: When several faults apply, the reported one follows the order: segment fault, then protection error, then limit error, then page fault.
- R6: Bit 16 of the page-table entry is its present flag. If it is 0, the status is 4 (page fault).
- R7: On success the status is 0 and the physical address is {entry bits [15:0], offset}.
- R8: Exactly one status code from 0 to 4 is reported per request. The physical address reads 0 for any non-zero status.
- R9: A descriptor write is visible to every request accepted after it. It does not affect a request that is already accepted.
- R10: req_ready is high only when no translation is in flight. A result is held stable until rsp_ready is high. A memory read request holds its address until mem_rd_ready is high.
- R11: After reset the block is idle with rsp_valid and mem_rd_valid low, and every segment reads as not loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| st_we | input | 1 | Descriptor write strobe |
| st_idx | input | 3 | Descriptor index to write |
| st_valid | input | 1 | Loaded flag to write |
| st_perm | input | 3 | Rights to write: bit0 read, bit1 write, bit2 execute |
| st_limit | input | 14 | Byte limit to write |
| st_base | input | 16 | Page-table base address to write |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 16 | Virtual address |
| req_acc | input | 2 | Access type code |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result accepted |
| rsp_status | output | 3 | Result status code |
| rsp_paddr | output | 24 | Physical address |
| mem_rd_valid | output | 1 | Page-table read request |
| mem_rd_ready | input | 1 | Read request accepted |
| mem_addr | output | 16 | Page-table entry address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rdata | input | 17 | Page-table entry: bit16 present, bits 15:0 frame |

## Verification
On every cycle, the assertions check the handshake rules: one translation at a time, results held while stalled, and read requests held until granted. They also check that a missing segment answers straight away with no memory read, that an absent page entry turns into a page fault, that the status code stays in range, and that descriptor writes land. Only the bench scenarios can show the numerical results. These are the exact limit boundary on a partial last page, the priority between overlapping faults, the page-table address wrap, the frame and offset join, and the rule that a descriptor rewritten mid-flight leaves the pending request untouched.

// File: rtl/spt_pkg.sv
package spt_pkg;

  typedef enum logic [2:0] {
    XS_OK         = 3'd0,
    XS_SEG_FAULT  = 3'd1,
    XS_PROT_ERR   = 3'd2,
    XS_LIMIT_ERR  = 3'd3,
    XS_PAGE_FAULT = 3'd4
  } xlt_status_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_MREQ  = 2'd1,
    FS_MWAIT = 2'd2,
    FS_RESP  = 2'd3
  } xlt_state_e;

  localparam int PERM_W = 3;

endpackage

// File: rtl/spt_rst_sync.sv
module spt_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n = sync_q[1];

endmodule

// File: rtl/spt_seg_table.sv
module spt_seg_table #(
  parameter int SEGS   = 8,
  parameter int LIM_W  = 14,
  parameter int BASE_W = 16,
  parameter int PERM_W = 3,
  parameter int IDX_W  = $clog2(SEGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [PERM_W-1:0] wr_perm,
  input  logic [LIM_W-1:0]  wr_limit,
  input  logic [BASE_W-1:0] wr_base,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [PERM_W-1:0] rd_perm,
  output logic [LIM_W-1:0]  rd_limit,
  output logic [BASE_W-1:0] rd_base
);

  logic [SEGS-1:0]   valid_vec;
  logic [PERM_W-1:0] perm_arr  [SEGS];
  logic [LIM_W-1:0]  limit_arr [SEGS];
  logic [BASE_W-1:0] base_arr  [SEGS];

  for (genvar g = 0; g < SEGS; g++) begin : g_ent
    logic              hit;
    logic              v_q;
    logic [PERM_W-1:0] p_q;
    logic [LIM_W-1:0]  l_q;
    logic [BASE_W-1:0] b_q;

    assign hit = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   v_q <= 1'b0;
      else if (hit) v_q <= wr_valid;
    end

    always_ff @(posedge clk) begin
      if (hit) begin
        p_q <= wr_perm;
        l_q <= wr_limit;
        b_q <= wr_base;
      end
    end

    assign valid_vec[g] = v_q;
    assign perm_arr[g]  = p_q;
    assign limit_arr[g] = l_q;
    assign base_arr[g]  = b_q;
  end

  assign rd_valid = valid_vec[rd_idx];
  assign rd_perm  = perm_arr[rd_idx];
  assign rd_limit = limit_arr[rd_idx];
  assign rd_base  = base_arr[rd_idx];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_vec[$past(wr_idx)] == $past(wr_valid)); // R9

endmodule

// File: rtl/spt_check.sv
module spt_check
  import spt_pkg::*;
#(
  parameter int PAGE_W = 5,
  parameter int OFF_W  = 8,
  parameter int LIM_W  = PAGE_W + OFF_W + 1
) (
  input  logic              seg_valid,
  input  logic [PERM_W-1:0] perm,
  input  logic [LIM_W-1:0]  limit,
  input  logic [1:0]        acc,
  input  logic [PAGE_W-1:0] page,
  input  logic [OFF_W-1:0]  offset,
  output xlt_status_e       status,
  output logic              pass
);

  localparam int SPAN_W = PAGE_W + OFF_W;

  logic              perm_ok;
  logic [LIM_W-1:0]  seg_pos;

  always_comb begin
    unique case (acc_e'(acc))
      ACC_READ:  perm_ok = perm[0];
      ACC_WRITE: perm_ok = perm[1];
      ACC_EXEC:  perm_ok = perm[2];
      default:   perm_ok = 1'b0;
    endcase
  end

  assign seg_pos = {{(LIM_W-SPAN_W){1'b0}}, page, offset};

  always_comb begin
    if (!seg_valid)         status = XS_SEG_FAULT;
    else if (!perm_ok)      status = XS_PROT_ERR;
    else if (seg_pos >= limit) status = XS_LIMIT_ERR;
    else                    status = XS_OK;
  end

  assign pass = (status == XS_OK);

endmodule

// File: rtl/seg_page_xlate.sv
module seg_page_xlate
  import spt_pkg::*;
#(
  parameter int SEGS    = 8,
  parameter int PAGE_W  = 5,
  parameter int OFF_W   = 8,
  parameter int PA_W    = 24,
  parameter int BASE_W  = 16,
  parameter int SEG_W   = $clog2(SEGS),
  parameter int VA_W    = SEG_W + PAGE_W + OFF_W,
  parameter int FRAME_W = PA_W - OFF_W,
  parameter int LIM_W   = PAGE_W + OFF_W + 1,
  parameter int PTE_W   = FRAME_W + 1
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              st_we,
  input  logic [SEG_W-1:0]  st_idx,
  input  logic              st_valid,
  input  logic [2:0]        st_perm,
  input  logic [LIM_W-1:0]  st_limit,
  input  logic [BASE_W-1:0] st_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_acc,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [2:0]        rsp_status,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [BASE_W-1:0] mem_addr,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rdata
);

  logic rst_n;

  logic [SEG_W-1:0]  va_seg;
  logic [PAGE_W-1:0] va_page;
  logic [OFF_W-1:0]  va_off;

  logic              ent_valid;
  logic [PERM_W-1:0] ent_perm;
  logic [LIM_W-1:0]  ent_limit;
  logic [BASE_W-1:0] ent_base;

  xlt_status_e chk_status;
  logic        chk_pass;

  xlt_state_e        state_q, state_d;
  xlt_status_e       status_q, status_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic [OFF_W-1:0]  off_q, off_d;
  logic [BASE_W-1:0] base_q, base_d;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic              accept;

  spt_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  assign {va_seg, va_page, va_off} = req_vaddr;

  spt_seg_table #(
    .SEGS   (SEGS),
    .LIM_W  (LIM_W),
    .BASE_W (BASE_W),
    .PERM_W (PERM_W),
    .IDX_W  (SEG_W)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (st_we),
    .wr_idx   (st_idx),
    .wr_valid (st_valid),
    .wr_perm  (st_perm),
    .wr_limit (st_limit),
    .wr_base  (st_base),
    .rd_idx   (va_seg),
    .rd_valid (ent_valid),
    .rd_perm  (ent_perm),
    .rd_limit (ent_limit),
    .rd_base  (ent_base)
  );

  spt_check #(
    .PAGE_W (PAGE_W),
    .OFF_W  (OFF_W),
    .LIM_W  (LIM_W)
  ) u_check (
    .seg_valid (ent_valid),
    .perm      (ent_perm),
    .limit     (ent_limit),
    .acc       (req_acc),
    .page      (va_page),
    .offset    (va_off),
    .status    (chk_status),
    .pass      (chk_pass)
  );

  assign req_ready    = (state_q == FS_IDLE);
  assign accept       = req_valid && req_ready;
  assign mem_rd_valid = (state_q == FS_MREQ);
  assign mem_addr     = base_q + {{(BASE_W-PAGE_W){1'b0}}, page_q};
  assign rsp_valid    = (state_q == FS_RESP);
  assign rsp_status   = status_q;
  assign rsp_paddr    = (status_q == XS_OK) ? {frame_q, off_q} : '0;

  always_comb begin
    state_d  = state_q;
    status_d = status_q;
    page_d   = page_q;
    off_d    = off_q;
    base_d   = base_q;
    frame_d  = frame_q;
    unique case (state_q)
      FS_IDLE: begin
        if (accept) begin
          page_d   = va_page;
          off_d    = va_off;
          base_d   = ent_base;
          frame_d  = '0;
          status_d = chk_status;
          state_d  = chk_pass ? FS_MREQ : FS_RESP;
        end
      end
      FS_MREQ: begin
        if (mem_rd_ready) state_d = FS_MWAIT;
      end
      FS_MWAIT: begin
        if (mem_rsp_valid) begin
          if (mem_rdata[FRAME_W]) begin
            status_d = XS_OK;
            frame_d  = mem_rdata[FRAME_W-1:0];
          end else begin
            status_d = XS_PAGE_FAULT;
            frame_d  = '0;
          end
          state_d = FS_RESP;
        end
      end
      FS_RESP: begin
        if (rsp_ready) state_d = FS_IDLE;
      end
      default: state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= FS_IDLE;
      status_q <= XS_OK;
    end else begin
      state_q  <= state_d;
      status_q <= status_d;
    end
  end

  always_ff @(posedge clk) begin
    page_q  <= page_d;
    off_q   <= off_d;
    base_q  <= base_d;
    frame_q <= frame_d;
  end

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!rsp_valid && !mem_rd_valid)); // R10

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_status) && $stable(rsp_paddr))); // R10

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_addr))); // R10

  AST_SEG_FAULT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !ent_valid) |=> (!mem_rd_valid && rsp_valid && rsp_status == 3'd1)); // R2

  AST_ABSENT_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FS_MWAIT && mem_rsp_valid && !mem_rdata[FRAME_W]) |=> (rsp_valid && rsp_status == 3'd4)); // R6

  AST_STATUS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_status <= 3'd4)); // R8

endmodule

// File: tb/seg_page_xlate_bench.sv
`timescale 1ns/1ps
module seg_page_xlate_bench;

  logic        clk;
  logic        arst_n;
  logic        st_we;
  logic [2:0]  st_idx;
  logic        st_valid;
  logic [2:0]  st_perm;
  logic [13:0] st_limit;
  logic [15:0] st_base;
  logic        req_valid;
  logic        req_ready;
  logic [15:0] req_vaddr;
  logic [1:0]  req_acc;
  logic        rsp_valid;
  logic        rsp_ready;
  logic [2:0]  rsp_status;
  logic [23:0] rsp_paddr;
  logic        mem_rd_valid;
  logic        mem_rd_ready;
  logic [15:0] mem_addr;
  logic        mem_rsp_valid;
  logic [16:0] mem_rdata;

  seg_page_xlate u_seg_page_xlate (
    .clk(clk), .arst_n(arst_n),
    .st_we(st_we), .st_idx(st_idx), .st_valid(st_valid), .st_perm(st_perm),
    .st_limit(st_limit), .st_base(st_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_acc(req_acc),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status), .rsp_paddr(rsp_paddr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  int mem_reads = 0;
  logic [15:0] last_addr = '0;

  bit          sh_valid [8];
  logic [2:0]  sh_perm  [8];
  logic [13:0] sh_limit [8];
  logic [15:0] sh_base  [8];

  function automatic logic [16:0] pte_fn(input logic [15:0] a);
    logic pres;
    pres = (a[2:0] != 3'd5);
    return {pres, ({a[7:0], a[15:8]} ^ 16'h3C5A)};
  endfunction

  function automatic logic [2:0] exp_status(input logic [15:0] va, input logic [1:0] acc);
    logic [2:0] s;
    logic ok;
    s = va[15:13];
    case (acc)
      2'd0: ok = sh_perm[s][0];
      2'd1: ok = sh_perm[s][1];
      2'd2: ok = sh_perm[s][2];
      default: ok = 1'b0;
    endcase
    if (!sh_valid[s]) return 3'd1;
    if (!ok) return 3'd2;
    if ({1'b0, va[12:0]} >= sh_limit[s]) return 3'd3;
    if (!pte_fn(sh_base[s] + {11'd0, va[12:8]})[16]) return 3'd4;
    return 3'd0;
  endfunction

  task automatic chk(input bit cond, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic write_seg(input logic [2:0] idx, input bit v, input logic [2:0] p,
                           input logic [13:0] lim, input logic [15:0] b);
    st_we = 1'b1; st_idx = idx; st_valid = v; st_perm = p; st_limit = lim; st_base = b;
    @(negedge clk);
    st_we = 1'b0;
    sh_valid[idx] = v; sh_perm[idx] = p; sh_limit[idx] = lim; sh_base[idx] = b;
  endtask

  task automatic xlate(input logic [15:0] va, input logic [1:0] acc,
                       input bit mid_inv, input string tag);
    logic [2:0]  es;
    logic [23:0] ep;
    logic [15:0] ea;
    int          r0;
    int          hold;
    logic [2:0]  s0;
    logic [23:0] p0;
    es = exp_status(va, acc);
    ea = sh_base[va[15:13]] + {11'd0, va[12:8]};
    ep = (es == 3'd0) ? {pte_fn(ea)[15:0], va[7:0]} : 24'd0;
    r0 = mem_reads;
    while (!req_ready) @(negedge clk);
    req_vaddr = va; req_acc = acc; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10", {tag, " busy after accept"}, req_ready, 0);
    if (mid_inv) write_seg(va[15:13], 1'b0, 3'd0, 14'd0, 16'd0);
    while (!rsp_valid) @(negedge clk);
    s0 = rsp_status; p0 = rsp_paddr;
    hold = $urandom % 3;
    for (int i = 0; i < hold; i++) @(negedge clk);
    chk(rsp_valid && rsp_status == s0 && rsp_paddr == p0, "R10", {tag, " result held"}, rsp_paddr, p0);
    chk(rsp_status == es, "R5", {tag, " status"}, rsp_status, es);
    chk(rsp_paddr == ep, "R7", {tag, " paddr"}, rsp_paddr, ep);
    if (es == 3'd0 || es == 3'd4) begin
      chk(mem_reads == r0 + 1, "R1", {tag, " one PTE read"}, mem_reads - r0, 1);
      chk(last_addr == ea, "R1", {tag, " PTE address"}, last_addr, ea);
    end else begin
      chk(mem_reads == r0, "R4", {tag, " no memory read on early fault"}, mem_reads - r0, 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  initial begin
    mem_rd_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_rd_valid) begin
        for (int d = int'($urandom % 3); d > 0; d--) @(negedge clk);
        mem_rd_ready = 1'b1;
        last_addr = mem_addr;
        mem_reads++;
        @(negedge clk);
        mem_rd_ready = 1'b0;
        for (int d = int'($urandom % 2); d > 0; d--) @(negedge clk);
        mem_rdata = pte_fn(last_addr);
        mem_rsp_valid = 1'b1;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 8; i++) begin
      sh_valid[i] = 0; sh_perm[i] = 0; sh_limit[i] = 0; sh_base[i] = 0;
    end
    arst_n = 1'b0; st_we = 0; st_idx = 0; st_valid = 0; st_perm = 0; st_limit = 0; st_base = 0;
    req_valid = 0; req_vaddr = 0; req_acc = 0; rsp_ready = 0;
    repeat (4) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk(req_ready == 1'b1, "R11", "idle after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R11", "no result after reset", rsp_valid, 0);
    chk(mem_rd_valid == 1'b0, "R11", "no read after reset", mem_rd_valid, 0);
    for (int s = 0; s < 8; s++) xlate({s[2:0], 13'h0}, 2'd0, 0, "R11 unloaded");

    write_seg(3'd0, 1, 3'b001, 14'd8192, 16'h1000);
    write_seg(3'd1, 1, 3'b100, 14'h0150, 16'h2000);
    write_seg(3'd2, 0, 3'b111, 14'd8192, 16'h3000);
    write_seg(3'd3, 1, 3'b011, 14'h1000, 16'hFFF8);

    xlate({3'd2, 5'd0, 8'h10}, 2'd0, 0, "R2 seg fault");
    xlate({3'd2, 5'd1, 8'h00}, 2'd3, 0, "R5 seg before prot");
    xlate({3'd0, 5'd1, 8'h00}, 2'd1, 0, "R3 write denied");
    xlate({3'd0, 5'd1, 8'h00}, 2'd3, 0, "R3 code 3 denied");
    xlate({3'd1, 5'd5, 8'h00}, 2'd0, 0, "R5 prot before limit");
    xlate({3'd1, 5'd1, 8'h4F}, 2'd2, 0, "R4 last byte inside");
    xlate({3'd1, 5'd1, 8'h50}, 2'd2, 0, "R4 first byte outside");
    xlate({3'd1, 5'd5, 8'h00}, 2'd2, 0, "R5 limit before page");
    xlate({3'd0, 5'd31, 8'hFF}, 2'd0, 0, "R4 full segment");
    xlate({3'd0, 5'd5, 8'h20}, 2'd0, 0, "R6 absent page");
    xlate({3'd3, 5'd10, 8'h33}, 2'd1, 0, "R1 base wrap");
    xlate({3'd0, 5'd2, 8'h44}, 2'd0, 1, "R9 in-flight rewrite");
    xlate({3'd0, 5'd2, 8'h44}, 2'd0, 0, "R9 next sees write");
    write_seg(3'd0, 1, 3'b001, 14'd8192, 16'h1000);
    xlate({3'd0, 5'd2, 8'h44}, 2'd0, 0, "R9 reload");

    for (int n = 0; n < 200; n++) begin
      if (($urandom % 6) == 0) begin
        logic [2:0] ri;
        logic [13:0] rl;
        ri = 3'($urandom);
        rl = (($urandom % 4) == 0) ? 14'd8192 : 14'($urandom % 8192);
        write_seg(ri, (($urandom % 4) != 0), 3'($urandom), rl, 16'($urandom));
      end
      xlate(16'($urandom), 2'($urandom), 0, "R8 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule